// File: doc/BRIEF.md
# Cascadable Synchronous Binary Counter

This block is a synchronous binary up-counter built from identical 4-bit slices. All slices share one clock, an active-low asynchronous clear, an active-low synchronous load strobe and one common count enable. Each slice also has a second, carry-gating enable. That enable both qualifies the slice's increment and gates its terminal-count output, which is high when the slice holds all ones.

A parameter sets the number of slices. Inside the chain, the terminal-count output of each slice drives the carry-gating enable of the slice above it. The carry-gating enable of the lowest slice comes from a chain input. The chain therefore behaves as one wide counter, and the common enable can stop every slice at once without waiting on the carry path. The carry output of the top slice is brought out so that chains can themselves be cascaded.

Typical uses are event tallies, clock-enable dividers and sequential address generators that need a preset start value.

Top module: `bcc_chain`

## Requirements
- R1: When `rst_ni` and `load_ni` are high and both `cnt_en_i` and `carry_en_i` are high, each rising clock edge adds one to `count_o`. `count_o[0]` is the least significant bit, and slice k holds bits [4k+3:4k] of one natural binary value.
- R2: With counting enabled, the edge after `count_o` is all ones returns it to zero. No output other than `carry_o` marks this wrap.
- R3: A low level on `rst_ni` forces `count_o` to zero at once, without a clock edge. Zero is held while `rst_ni` stays low, whatever `load_ni`, `data_i` and the enables do.
- R4: With `rst_ni` high and `load_ni` low, the next rising edge copies `data_i` into `count_o`. This happens whatever the state of both enables, and load takes priority over counting and holding.
- R5: With `rst_ni` and `load_ni` high and `cnt_en_i` low, clock edges leave `count_o` unchanged.
- R6: With `rst_ni` and `load_ni` high and `carry_en_i` low, clock edges leave `count_o` unchanged.
- R7: `carry_o` is high exactly when `count_o` is all ones and `carry_en_i` is high. It responds combinationally in the same cycle, and `cnt_en_i` has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Common clock, rising edge active |
| rst_ni | input | 1 | Asynchronous clear, active low |
| load_ni | input | 1 | Synchronous parallel load strobe, active low |
| data_i | input | 4*N_SLICES | Parallel load value |
| cnt_en_i | input | 1 | Common count enable shared by all slices |
| carry_en_i | input | 1 | Carry-gating enable of the lowest slice |
| count_o | output | 4*N_SLICES | Current count, bit 0 least significant |
| carry_o | output | 1 | Terminal count of the top slice |

## Verification
The assertions assume that `rst_ni` is released only away from a rising clock edge. They also assume that the control inputs change only between edges, so that the value sampled at an edge is the value the flops act on. The bench follows these rules by driving every input, including the clear, just after a falling edge. The single exception is a deliberate mid-cycle clear, which is applied between edges and removed at a falling edge. The clocked assertions are disabled while the clear is low. The immediate-effect property of the clear is checked by the bench at the ports, before the next rising edge arrives.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
  localparam int unsigned SLICE_W = 4;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_INC  = 2'd2
  } slice_op_e;
endpackage

// File: rtl/bcc_ctrl.sv
module bcc_ctrl
  import bcc_pkg::*;
(
  input  logic      load_ni,
  input  logic      en_p_i,
  input  logic      en_t_i,
  output slice_op_e op_o
);
  // load outranks count; count needs both enables
  always_comb begin
    if (!load_ni)               op_o = OP_LOAD;
    else if (en_p_i && en_t_i)  op_o = OP_INC;
    else                        op_o = OP_HOLD;
  end
endmodule

// File: rtl/bcc_tc_decode.sv
module bcc_tc_decode #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] q_i,
  input  logic         en_t_i,
  output logic         tc_o
);
  assign tc_o = en_t_i && (&q_i);
endmodule

// File: rtl/bcc_slice.sv
module bcc_slice
  import bcc_pkg::*;
#(
  parameter int unsigned W = SLICE_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_ni,
  input  logic [W-1:0] d_i,
  input  logic         en_p_i,
  input  logic         en_t_i,
  output logic [W-1:0] q_o,
  output logic         tc_o
);
  slice_op_e    op;
  logic [W-1:0] q_q;

  bcc_ctrl u_ctrl (
    .load_ni (load_ni),
    .en_p_i  (en_p_i),
    .en_t_i  (en_t_i),
    .op_o    (op)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q <= '0;
    end else begin
      unique case (op)
        OP_LOAD: q_q <= d_i;
        OP_INC:  q_q <= q_q + 1'b1;
        default: q_q <= q_q;
      endcase
    end
  end

  bcc_tc_decode #(.W(W)) u_tc (
    .q_i    (q_q),
    .en_t_i (en_t_i),
    .tc_o   (tc_o)
  );

  assign q_o = q_q;
endmodule

// File: rtl/bcc_chain.sv
module bcc_chain
  import bcc_pkg::*;
#(
  parameter int unsigned N_SLICES = 2,
  localparam int unsigned TOTAL_W = N_SLICES * SLICE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_ni,
  input  logic [TOTAL_W-1:0] data_i,
  input  logic               cnt_en_i,
  input  logic               carry_en_i,
  output logic [TOTAL_W-1:0] count_o,
  output logic               carry_o
);
  // carry[k] gates slice k; carry[N_SLICES] is the chain output
  logic [N_SLICES:0] carry;

  assign carry[0] = carry_en_i;

  for (genvar k = 0; k < N_SLICES; k++) begin : g_slice
    bcc_slice #(.W(SLICE_W)) u_slice (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_ni (load_ni),
      .d_i     (data_i[k*SLICE_W +: SLICE_W]),
      .en_p_i  (cnt_en_i),
      .en_t_i  (carry[k]),
      .q_o     (count_o[k*SLICE_W +: SLICE_W]),
      .tc_o    (carry[k+1])
    );
  end

  assign carry_o = carry[N_SLICES];
endmodule

// File: rtl/bcc_chain_chk.sv
module bcc_chain_chk #(
  parameter int unsigned TOTAL_W = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               load_ni,
  input logic [TOTAL_W-1:0] data_i,
  input logic               cnt_en_i,
  input logic               carry_en_i,
  input logic [TOTAL_W-1:0] count_o,
  input logic               carry_o
);
  assert_count_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && cnt_en_i && carry_en_i) |=>
      count_o == TOTAL_W'($past(count_o) + 1'b1));

  assert_wrap_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && cnt_en_i && carry_en_i && (&count_o)) |=> count_o == '0);

  assert_clear_release_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> count_o == '0);

  assert_load_takes_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_ni |=> count_o == $past(data_i));

  assert_hold_common_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !cnt_en_i) |=> $stable(count_o));

  assert_hold_carry_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !carry_en_i) |=> $stable(count_o));

  assert_carry_full_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o |-> ((&count_o) && carry_en_i));

  assert_carry_seen_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((&count_o) && carry_en_i) |-> carry_o);
endmodule

bind bcc_chain bcc_chain_chk #(.TOTAL_W(TOTAL_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .load_ni    (load_ni),
  .data_i     (data_i),
  .cnt_en_i   (cnt_en_i),
  .carry_en_i (carry_en_i),
  .count_o    (count_o),
  .carry_o    (carry_o)
);

// File: tb/sim_bcc_chain.sv
`timescale 1ns/1ps
module sim_bcc_chain;
  localparam int unsigned NS = 2;
  localparam int unsigned W  = NS * 4;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b1;
  logic         load_ni = 1'b1;
  logic [W-1:0] data_i = '0;
  logic         cnt_en_i = 1'b0;
  logic         carry_en_i = 1'b0;
  logic [W-1:0] count_o;
  logic         carry_o;

  logic [W-1:0] model = '0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  bcc_chain #(.N_SLICES(NS)) u0 (
    .clk_i, .rst_ni, .load_ni, .data_i, .cnt_en_i, .carry_en_i, .count_o, .carry_o
  );

  task automatic check(input string req);
    logic exp_c;
    exp_c = (&model) && carry_en_i;
    checks++;
    if (count_o !== model || carry_o !== exp_c) begin
      errors++;
      $display("FAIL %s: count=%h carry=%b expected count=%h carry=%b",
               req, count_o, carry_o, model, exp_c);
    end
  endtask

  // one edge: model follows the requirements, sampled at next falling edge
  task automatic tick();
    if (!rst_ni)                      model = '0;
    else if (!load_ni)                model = data_i;
    else if (cnt_en_i && carry_en_i)  model = model + 1'b1;
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    @(negedge clk_i); rst_ni = 1'b0; model = '0;
    #1 check("R3");
    @(negedge clk_i); rst_ni = 1'b1;
    #1 check("R3");
  endtask

  task automatic t_count();
    load_ni = 1'b1; cnt_en_i = 1'b1; carry_en_i = 1'b1;
    for (int i = 0; i < 40; i++) begin
      tick(); check("R1");
    end
  endtask

  task automatic t_wrap();
    data_i = 8'hFD; load_ni = 1'b0; tick(); check("R4");
    load_ni = 1'b1;
    for (int i = 0; i < 4; i++) begin
      tick(); check((model == '0) ? "R2" : "R7");
    end
    data_i = 8'h0E; load_ni = 1'b0; tick(); check("R4");
    load_ni = 1'b1; tick(); check("R1");
    tick(); check("R1");
  endtask

  task automatic t_hold_common();
    data_i = 8'h3C; load_ni = 1'b0; tick(); load_ni = 1'b1;
    cnt_en_i = 1'b0; carry_en_i = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick(); check("R5");
    end
    cnt_en_i = 1'b1; tick(); check("R1");
  endtask

  task automatic t_hold_carry();
    cnt_en_i = 1'b1; carry_en_i = 1'b0;
    for (int i = 0; i < 3; i++) begin
      tick(); check("R6");
    end
    carry_en_i = 1'b1; tick(); check("R1");
  endtask

  task automatic t_load_disabled();
    cnt_en_i = 1'b0; carry_en_i = 1'b0;
    data_i = 8'hA5; load_ni = 1'b0; tick(); check("R4");
    cnt_en_i = 1'b1; carry_en_i = 1'b1;
    data_i = 8'h5A; tick(); check("R4");
    load_ni = 1'b1;
  endtask

  task automatic t_carry();
    data_i = 8'hFF; load_ni = 1'b0; cnt_en_i = 1'b0; carry_en_i = 1'b1;
    tick(); load_ni = 1'b1;
    #1 check("R7");
    carry_en_i = 1'b0; #1 check("R7");
    carry_en_i = 1'b1; cnt_en_i = 1'b1; #1 check("R7");
    tick(); check("R2");
  endtask

  task automatic t_clear_mid();
    cnt_en_i = 1'b1; carry_en_i = 1'b1; load_ni = 1'b1;
    data_i = 8'h77;
    for (int i = 0; i < 5; i++) tick();
    check("R1");
    #2 rst_ni = 1'b0; load_ni = 1'b0; model = '0;
    #1 check("R3");
    @(negedge clk_i); check("R3");
    rst_ni = 1'b1; load_ni = 1'b1;
    tick(); check("R1");
  endtask

  initial begin
    t_reset();
    t_count();
    t_wrap();
    t_hold_common();
    t_hold_carry();
    t_load_disabled();
    t_carry();
    t_clear_mid();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule